// File: doc/BRIEF.md
# Guard-Round-Sticky Rounding Unit

This block is a purely combinational rounding stage for a floating-point datapath. It receives a sign, a wide mantissa whose two lowest bits hold the guard bit (bit 1) and the round bit (bit 0), a separate sticky bit, and a two-bit rounding-mode field. It returns the mantissa two bits narrower, with guard and round discarded. The result is incremented by one when the selected mode calls for it.

Alongside the rounded mantissa it reports three flags. The first shows that an increment was applied. The second shows that any discarded information was nonzero. The third is a carry-out, raised when the increment wrapped the mantissa to the next power of two. The caller owns exponent adjustment, renormalisation after a carry, and exception handling. The block corrects nothing itself.

Top module: `grs_round_unit`

## Requirements
- R1: `mant_o` equals `mant_i` shifted right by two (guard `mant_i[1]` and round `mant_i[0]` dropped), plus one when an increment is applied; the sum is taken modulo 2^(MANT_W-2).
- R2: When guard, round and sticky are all zero, no increment is applied and `inexact_o` is 0, in every mode.
- R3: When any of guard, round or sticky is 1, `inexact_o` is 1, in every mode.
- R4: Mode 0 (nearest, ties to even) increments only when guard is 1 and at least one of these is 1: round, sticky, or the shifted result's LSB `mant_i[2]`.
- R5: Mode 1 (toward zero) never increments.
- R6: Mode 2 (toward plus infinity) increments exactly when the value is inexact and `sign_i` is 0.
- R7: Mode 3 (toward minus infinity) increments exactly when the value is inexact and `sign_i` is 1.
- R8: The increment carries across the whole output width. `carry_o` is 1 exactly when an all-ones shifted mantissa is incremented, and `mant_o` is then all zeros.
- R9: `rounded_up_o` is 1 exactly when an increment was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mant_i | input | MANT_W | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits below the round bit |
| mode_i | input | 2 | Rounding mode: 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_o | output | MANT_W-2 | Rounded mantissa without guard and round |
| rounded_up_o | output | 1 | An increment was applied |
| inexact_o | output | 1 | Discarded bits were nonzero |
| carry_o | output | 1 | Increment wrapped past the top bit |

## Verification
The checker examines every evaluation of the block. It confirms that exact inputs never round or flag inexact, and that inputs with a nonzero guard, round or sticky bit always flag inexact. It also confirms that toward-zero mode and the wrong-sign directed modes never round up, that nearest mode never rounds up with a clear guard bit, and that any increment yields exactly the truncated value plus one, with the carry flag matching. Only the bench's scenarios show which way a nearest-mode tie breaks on odd and even LSBs, and that the directed modes do round up for the correct sign. The bench also covers the all-ones wrap and arbitrary wide mantissa patterns against an independent model.

// File: rtl/grs_round_pkg.sv
package grs_round_pkg;

    typedef enum logic [1:0] {
        RMODE_NEAREST = 2'd0,
        RMODE_TO_ZERO = 2'd1,
        RMODE_TO_POS  = 2'd2,
        RMODE_TO_NEG  = 2'd3
    } rmode_t;

endpackage

// File: rtl/grs_round_decide.sv
module grs_round_decide
    import grs_round_pkg::*;
(
    input  logic   guard_i,
    input  logic   rnd_i,
    input  logic   sticky_i,
    input  logic   lsb_i,
    input  logic   sign_i,
    input  rmode_t mode_i,
    output logic   inexact_o,
    output logic   bump_o
);

    logic lost;

    always_comb begin
        lost = guard_i | rnd_i | sticky_i;
    end

    always_comb begin
        bump_o = 1'b0;
        unique case (mode_i)
            RMODE_NEAREST: bump_o = guard_i & (rnd_i | sticky_i | lsb_i);
            RMODE_TO_ZERO: bump_o = 1'b0;
            RMODE_TO_POS:  bump_o = lost & ~sign_i;
            RMODE_TO_NEG:  bump_o = lost & sign_i;
            default:       bump_o = 1'b0;
        endcase
    end

    always_comb begin
        inexact_o = lost;
    end

endmodule

// File: rtl/grs_round_inc.sv
module grs_round_inc #(
    parameter int W = 26
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W:0] chain;

    assign chain[0] = cin_i;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            assign sum_o[b]     = a_i[b] ^ chain[b];
            assign chain[b + 1] = a_i[b] & chain[b];
        end
    endgenerate

    assign cout_o = chain[W];

endmodule

// File: rtl/grs_round_unit.sv
module grs_round_unit
    import grs_round_pkg::*;
#(
    parameter int MANT_W = 28
) (
    input  logic              sign_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    input  logic [1:0]        mode_i,
    output logic [MANT_W-3:0] mant_o,
    output logic              rounded_up_o,
    output logic              inexact_o,
    output logic              carry_o
);

    localparam int OUT_W = MANT_W - 2;

    logic [OUT_W-1:0] trunc;
    logic             bump;
    rmode_t           mode;

    assign trunc = mant_i[MANT_W-1:2];
    assign mode  = rmode_t'(mode_i);

    grs_round_decide u_decide (
        .guard_i   (mant_i[1]),
        .rnd_i     (mant_i[0]),
        .sticky_i  (sticky_i),
        .lsb_i     (mant_i[2]),
        .sign_i    (sign_i),
        .mode_i    (mode),
        .inexact_o (inexact_o),
        .bump_o    (bump)
    );

    grs_round_inc #(.W(OUT_W)) u_inc (
        .a_i    (trunc),
        .cin_i  (bump),
        .sum_o  (mant_o),
        .cout_o (carry_o)
    );

    assign rounded_up_o = bump;

endmodule

// File: rtl/grs_round_checker.sv
module grs_round_checker #(
    parameter int MANT_W = 28
) (
    input logic              sign_i,
    input logic [MANT_W-1:0] mant_i,
    input logic              sticky_i,
    input logic [1:0]        mode_i,
    input logic [MANT_W-3:0] mant_o,
    input logic              rounded_up_o,
    input logic              inexact_o,
    input logic              carry_o
);

    logic             lost;
    logic [MANT_W-2:0] plus_one;

    always_comb begin
        lost     = mant_i[1] | mant_i[0] | sticky_i;
        plus_one = {1'b0, mant_i[MANT_W-1:2]} + 1'b1;

        p_exact_quiet_r2: assert (lost || (!inexact_o && !rounded_up_o))
            else $error("exact input rounded or flagged");
        p_lost_flag_r3: assert (!lost || inexact_o)
            else $error("inexact not flagged");
        p_nearest_guard_r4: assert (!(mode_i == 2'd0 && !mant_i[1]) || !rounded_up_o)
            else $error("nearest rounded up with guard clear");
        p_toward_zero_r5: assert (mode_i != 2'd1 || !rounded_up_o)
            else $error("toward-zero rounded up");
        p_pos_sign_r6: assert (!(mode_i == 2'd2 && sign_i) || !rounded_up_o)
            else $error("toward +inf rounded up a negative value");
        p_neg_sign_r7: assert (!(mode_i == 2'd3 && !sign_i) || !rounded_up_o)
            else $error("toward -inf rounded up a positive value");
        p_carry_wrap_r8: assert (!carry_o || (rounded_up_o && mant_o == '0))
            else $error("carry without wrap to zero");
        p_bump_value_r9: assert (!rounded_up_o || {carry_o, mant_o} == plus_one)
            else $error("increment value wrong");
    end

endmodule

bind grs_round_unit grs_round_checker #(.MANT_W(MANT_W)) u_chk (.*);

// File: tb/sim_grs_round_unit.sv
module sim_grs_round_unit;

    localparam int CLK_PERIOD = 10;
    localparam int MW = 28;
    localparam int OW = MW - 2;
    localparam int NVEC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sign_i = 1'b0;
    logic [MW-1:0] mant_i = '0;
    logic          sticky_i = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic [OW-1:0] mant_o;
    logic          rounded_up_o, inexact_o, carry_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    grs_round_unit #(.MANT_W(MW)) u0 (
        .sign_i(sign_i), .mant_i(mant_i), .sticky_i(sticky_i), .mode_i(mode_i),
        .mant_o(mant_o), .rounded_up_o(rounded_up_o),
        .inexact_o(inexact_o), .carry_o(carry_o)
    );

    // {sign, mode, sticky, mantissa}
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 1'b0, 28'h0000004},
        {1'b0, 2'd0, 1'b0, 28'h0000006},
        {1'b0, 2'd0, 1'b0, 28'h000000A},
        {1'b0, 2'd0, 1'b1, 28'h0000002},
        {1'b0, 2'd0, 1'b0, 28'h0000005},
        {1'b1, 2'd0, 1'b0, 28'h0000007},
        {1'b0, 2'd1, 1'b1, 28'h0ABCDEF},
        {1'b1, 2'd1, 1'b0, 28'hFFFFFFF},
        {1'b0, 2'd2, 1'b0, 28'h1234561},
        {1'b1, 2'd2, 1'b1, 28'h1234560},
        {1'b0, 2'd2, 1'b0, 28'h1234564},
        {1'b1, 2'd3, 1'b0, 28'h8000002},
        {1'b0, 2'd3, 1'b1, 28'h8000000},
        {1'b1, 2'd3, 1'b0, 28'h7FFFFF8},
        {1'b0, 2'd0, 1'b0, 28'hFFFFFFE},
        {1'b1, 2'd2, 1'b1, 28'hFFFFFFC}
    };

    function automatic logic [OW+2:0] model(input logic s, input logic [1:0] md,
                                            input logic st, input logic [MW-1:0] m);
        logic g, r, lost, up;
        logic [OW:0] sum;
        g = m[1];
        r = m[0];
        lost = g | r | st;
        case (md)
            2'd0:    up = g & (r | st | m[2]);
            2'd1:    up = 1'b0;
            2'd2:    up = lost & ~s;
            default: up = lost & s;
        endcase
        sum = {1'b0, m[MW-1:2]} + {{OW{1'b0}}, up};
        return {lost, up, sum};
    endfunction

    task automatic apply(input logic s, input logic [1:0] md, input logic st,
                         input logic [MW-1:0] m, input string tag);
        logic [OW+2:0] exp_v;
        @(posedge clk);
        sign_i = s; mode_i = md; sticky_i = st; mant_i = m;
        @(negedge clk);
        exp_v = model(s, md, st, m);
        n_checks++;
        if ({inexact_o, rounded_up_o, carry_o, mant_o} !== exp_v) begin
            n_fails++;
            $display("FAIL %s: got inx=%0b up=%0b c=%0b m=%h, expected inx=%0b up=%0b c=%0b m=%h",
                     tag, inexact_o, rounded_up_o, carry_o, mant_o,
                     exp_v[OW+2], exp_v[OW+1], exp_v[OW], exp_v[OW-1:0]);
        end
    endtask

    task automatic expect_bit(input logic act, input logic want, input string tag);
        n_checks++;
        if (act !== want) begin
            n_fails++;
            $display("FAIL %s: got %0b, expected %0b", tag, act, want);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: all-zero inputs give all-zero outputs (R2)
        n_checks++;
        if ({mant_o, rounded_up_o, inexact_o, carry_o} !== '0) begin
            n_fails++;
            $display("FAIL R2 reset: got %h, expected 0", {mant_o, rounded_up_o, inexact_o, carry_o});
        end
        rst_n = 1'b1;

        // table walk covering R1 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++)
            apply(VEC[i][31], VEC[i][30:29], VEC[i][28], VEC[i][27:0], "R1/R4-R7 table");

        // R4 tie cases: odd LSB rounds up, even does not
        apply(1'b0, 2'd0, 1'b0, 28'h0000006, "R4 tie odd");
        expect_bit(rounded_up_o, 1'b1, "R4 tie odd up");
        apply(1'b0, 2'd0, 1'b0, 28'h000000A, "R4 tie even");
        expect_bit(rounded_up_o, 1'b0, "R4 tie even up");
        expect_bit(inexact_o, 1'b1, "R3 tie even inexact");

        // R2 exact in every mode
        for (int md = 0; md < 4; md++) begin
            apply(1'b1, md[1:0], 1'b0, 28'h5A5A5A4, "R2 exact");
            expect_bit(rounded_up_o | inexact_o, 1'b0, "R2 exact flags");
        end

        // R5 toward zero never rounds, even with all bits lost
        apply(1'b1, 2'd1, 1'b1, 28'h0000003, "R5 rtz");
        expect_bit(rounded_up_o, 1'b0, "R5 rtz up");

        // R6 / R7 sign dependence with only sticky set
        apply(1'b0, 2'd2, 1'b1, 28'h0000000, "R6 pos");
        expect_bit(rounded_up_o, 1'b1, "R6 pos up");
        apply(1'b1, 2'd2, 1'b1, 28'h0000000, "R6 neg");
        expect_bit(rounded_up_o, 1'b0, "R6 neg up");
        apply(1'b1, 2'd3, 1'b1, 28'h0000000, "R7 neg");
        expect_bit(rounded_up_o, 1'b1, "R7 neg up");
        apply(1'b0, 2'd3, 1'b1, 28'h0000000, "R7 pos");
        expect_bit(rounded_up_o, 1'b0, "R7 pos up");

        // R8 full carry wrap, R9 flag
        apply(1'b0, 2'd0, 1'b0, 28'hFFFFFFF, "R8 wrap");
        expect_bit(carry_o, 1'b1, "R8 carry");
        expect_bit(mant_o == '0, 1'b1, "R8 zero mant");
        expect_bit(rounded_up_o, 1'b1, "R9 flag on wrap");
        apply(1'b0, 2'd0, 1'b0, 28'h7FFFFFF, "R8 no wrap");
        expect_bit(carry_o, 1'b0, "R8 no carry");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule